// File: doc/BRIEF.md
# Cascadable Two-Stage Interval Timer

This block is a pair of 8-bit counters that run from clock-enable strobes inside a single clock domain. The first stage counts strobes of a slow auxiliary enable. From that count it produces a periodic refresh enable for a display driver, at one of four rates between one pulse per 32 strobes and one pulse per 256 strobes. The second stage produces no periodic output. It counts events from one of three sources and sets a sticky interrupt flag at a programmable interval.

When the two stages are not chained, the second stage counts either the auxiliary strobe or a faster sub-main strobe. When they are chained, the second stage advances once each time the first stage wraps, which is once per 256 auxiliary strobes. This gives long intervals without wider counters. A hold input freezes the second stage. It also freezes the first stage, but only when the stages are chained.

Top module: `cascade_tmr`

## Requirements
- R1: While `rst_n` is low at a clock edge, both counters return to zero, and `refresh_stb` and `irq_flag` are low on the following cycle.
- R2: With `rate_sel` = k (0 to 3), `refresh_stb` is high for exactly one cycle after every (32·2^k)-th counted auxiliary strobe. It first rises in the cycle after the (32·2^k)-th strobe since reset.
- R3: When `cascade` is 0, the second stage counts `aux_stb` if `src_sel` = 0 and `smc_stb` if `src_sel` = 1. Strobes on the strobe input that is not selected have no effect.
- R4: When `cascade` is 1, the second stage advances once per wrap of the first stage, which is once per 256 auxiliary strobes. `smc_stb` has no effect.
- R5: With `ival_sel` = j (0 to 7), `irq_flag` is set at the clock edge of the (2^(j+1))-th second-stage event counted from zero.
- R6: When `hold` = 1 and `cascade` = 0, the second stage keeps its count. The first stage and `refresh_stb` keep running.
- R7: When `hold` = 1 and `cascade` = 1, both stages keep their counts and `refresh_stb` stays low.
- R8: Once set, `irq_flag` stays high until a cycle in which `flag_clr` = 1 and no set event occurs. After that cycle it is low.
- R9: If a set event and `flag_clr` arrive in the same cycle, `irq_flag` is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aux_stb | input | 1 | Auxiliary clock-enable strobe |
| smc_stb | input | 1 | Sub-main clock-enable strobe |
| src_sel | input | 1 | Second-stage source when not chained: 0 auxiliary, 1 sub-main |
| cascade | input | 1 | Chain the second stage to the first stage wrap |
| hold | input | 1 | Freeze the second stage (and the first stage when chained) |
| rate_sel | input | 2 | Refresh divide: 32 shifted left by this value |
| ival_sel | input | 3 | Interrupt interval: 2 shifted left by this value |
| flag_clr | input | 1 | Clear the interrupt flag |
| refresh_stb | output | 1 | One-cycle refresh enable pulse |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench first checks the exact strobe count at which each refresh rate and each interrupt interval first fires. A tap placed one bit off would give a pulse one power of two early or late. In chained mode it checks that the flag needs 512 auxiliary strobes at the shortest interval, and that a long run of sub-main strobes leaves the flag clear. A design with the wrong source select would set the flag early. Hold is checked in both modes: in the unchained case refresh must keep running, in the chained case it must stop. A design that gated the wrong stage would show a refresh pulse or miss one. Finally the bench fires a clear and a set event in the same cycle. A design that gave the clear priority would drop that interrupt.

// File: rtl/cascade_tmr_pkg.sv
// Shared constants and types for the two-stage interval timer.
package cascade_tmr_pkg;
    localparam int unsigned CNT_W = 8;

    // Second-stage source when the stages are not chained
    typedef enum logic {
        SRC_AUX = 1'b0,
        SRC_SMC = 1'b1
    } src_e;
endpackage

// File: rtl/bt_div_stage.sv
// Strobe-driven binary counter with a selectable power-of-two tap.
// Assumes MIN_LOG2 + 2**SEL_W - 1 <= CNT_W. The hit output is high in a
// cycle where en is high and the low (MIN_LOG2+sel) count bits are all ones,
// i.e. the strobe that completes one period of the selected divide.
module bt_div_stage #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned MIN_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam int unsigned TAPS = 1 << SEL_W;

    logic [TAPS-1:0] taps;

    // Tap k is set when the low MIN_LOG2+k bits are all ones
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign taps[k] = &cnt[MIN_LOG2+k-1:0];
    end

    // Count one step for each enabled strobe
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (en) cnt <= cnt + 1'b1;
    end

    // Flag the strobe that completes the selected period
    always_comb hit = en & taps[sel];
endmodule

// File: rtl/bt_src_sel.sv
// Chooses the event that advances the second stage: the first stage wrap
// when chained, otherwise the auxiliary or sub-main strobe. Hold gates it.
module bt_src_sel
    import cascade_tmr_pkg::*;
(
    input  logic aux_stb,
    input  logic smc_stb,
    input  logic s1_wrap,
    input  src_e src,
    input  logic cascade,
    input  logic hold,
    output logic s2_en
);
    // Select and gate the second-stage advance
    always_comb begin
        if (hold)                s2_en = 1'b0;
        else if (cascade)        s2_en = s1_wrap;
        else if (src == SRC_SMC) s2_en = smc_stb;
        else                     s2_en = aux_stb;
    end
endmodule

// File: rtl/bt_irq_flag.sv
// Sticky interrupt flag. A set event has priority over a clear in the
// same cycle.
module bt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);
    // Hold the flag until cleared; set wins
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (set_ev) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end
endmodule

// File: rtl/cascade_tmr.sv
// Two-stage interval timer. Stage one divides the auxiliary strobe and
// drives a refresh enable at 32..256 strobes per pulse. Stage two counts a
// selected strobe or stage one's wrap, and sets a sticky flag every
// 2..256 events. Hold stops stage two, and stage one too when chained.
// All inputs are assumed synchronous to clk.
module cascade_tmr
    import cascade_tmr_pkg::*;
#(
    parameter int unsigned TMR_W         = CNT_W,
    parameter int unsigned RATE_W        = 2,
    parameter int unsigned IVAL_W        = 3,
    parameter int unsigned RATE_MIN_LOG2 = 5,
    parameter int unsigned IVAL_MIN_LOG2 = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_stb,
    input  logic              smc_stb,
    input  logic              src_sel,
    input  logic              cascade,
    input  logic              hold,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [IVAL_W-1:0] ival_sel,
    input  logic              flag_clr,
    output logic              refresh_stb,
    output logic              irq_flag
);
    logic             s1_en;
    logic [TMR_W-1:0] s1_cnt;
    logic             s1_hit;
    logic             s1_wrap;
    logic             s2_en;
    logic [TMR_W-1:0] s2_cnt;
    logic             s2_hit;

    // Stage one runs unless frozen by hold while chained
    always_comb s1_en = aux_stb & ~(hold & cascade);

    // Stage one full-period wrap feeds the chained second stage
    always_comb s1_wrap = s1_en & (&s1_cnt);

    bt_div_stage #(
        .CNT_W   (TMR_W),
        .SEL_W   (RATE_W),
        .MIN_LOG2(RATE_MIN_LOG2)
    ) u_stage1 (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s1_en),
        .sel  (rate_sel),
        .cnt  (s1_cnt),
        .hit  (s1_hit)
    );

    // Register the refresh enable as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) refresh_stb <= 1'b0;
        else        refresh_stb <= s1_hit;
    end

    bt_src_sel u_src (
        .aux_stb(aux_stb),
        .smc_stb(smc_stb),
        .s1_wrap(s1_wrap),
        .src    (src_e'(src_sel)),
        .cascade(cascade),
        .hold   (hold),
        .s2_en  (s2_en)
    );

    bt_div_stage #(
        .CNT_W   (TMR_W),
        .SEL_W   (IVAL_W),
        .MIN_LOG2(IVAL_MIN_LOG2)
    ) u_stage2 (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s2_en),
        .sel  (ival_sel),
        .cnt  (s2_cnt),
        .hit  (s2_hit)
    );

    bt_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_ev(s2_hit),
        .clr   (flag_clr),
        .flag  (irq_flag)
    );
endmodule

// File: rtl/cascade_tmr_chk.sv
// Property checker for cascade_tmr, attached through bind.
module cascade_tmr_chk #(
    parameter int unsigned TMR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             aux_stb,
    input logic             cascade,
    input logic             hold,
    input logic             flag_clr,
    input logic             refresh_stb,
    input logic             irq_flag,
    input logic [TMR_W-1:0] s1_cnt,
    input logic [TMR_W-1:0] s2_cnt,
    input logic             s2_hit
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (s1_cnt == '0 && s2_cnt == '0 && !refresh_stb && !irq_flag));

    // R2
    refresh_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb |-> $past(aux_stb));

    // R4
    casc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !aux_stb) |=> $stable(s2_cnt));

    // R6
    hold_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(s2_cnt));

    // R7
    hold_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && cascade) |=> $stable(s1_cnt));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_hit && flag_clr) |=> irq_flag);
endmodule

bind cascade_tmr cascade_tmr_chk #(.TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .aux_stb    (aux_stb),
    .cascade    (cascade),
    .hold       (hold),
    .flag_clr   (flag_clr),
    .refresh_stb(refresh_stb),
    .irq_flag   (irq_flag),
    .s1_cnt     (s1_cnt),
    .s2_cnt     (s2_cnt),
    .s2_hit     (s2_hit)
);

// File: tb/cascade_tmr_tb_top.sv
`timescale 1ns/1ps
module cascade_tmr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aux_stb = 1'b0;
    logic       smc_stb = 1'b0;
    logic       src_sel = 1'b0;
    logic       cascade = 1'b0;
    logic       hold = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [2:0] ival_sel = 3'd0;
    logic       flag_clr = 1'b0;
    logic       refresh_stb;
    logic       irq_flag;

    int n_run = 0;
    int n_fail = 0;
    int ref_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cascade_tmr dut_i (
        .clk(clk), .rst_n(rst_n), .aux_stb(aux_stb), .smc_stb(smc_stb),
        .src_sel(src_sel), .cascade(cascade), .hold(hold),
        .rate_sel(rate_sel), .ival_sel(ival_sel), .flag_clr(flag_clr),
        .refresh_stb(refresh_stb), .irq_flag(irq_flag)
    );

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One clock: drive at negedge, sample at the following negedge
    task automatic step(input logic a, input logic s, input logic c);
        aux_stb = a; smc_stb = s; flag_clr = c;
        @(posedge clk);
        @(negedge clk);
        if (refresh_stb) ref_cnt++;
        aux_stb = 1'b0; smc_stb = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic steps(input logic a, input logic s, input int n);
        for (int i = 0; i < n; i++) step(a, s, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        ref_cnt = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b0);
        check("R1 refresh in reset", int'(refresh_stb), 0);
        check("R1 flag in reset", int'(irq_flag), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_refresh();
        for (int k = 0; k < 4; k++) begin
            src_sel = 1'b0; cascade = 1'b0; hold = 1'b0;
            rate_sel = 2'(k);
            do_reset();
            steps(1'b1, 1'b0, 256);
            check($sformatf("R2 refresh count rate %0d", k), ref_cnt, 8 >> k);
        end
        rate_sel = 2'd0;
        do_reset();
        steps(1'b1, 1'b0, 31);
        check("R2 no refresh before 32nd", ref_cnt, 0);
        step(1'b1, 1'b0, 1'b0);
        check("R2 refresh at 32nd", int'(refresh_stb), 1);
        step(1'b0, 1'b0, 1'b0);
        check("R2 refresh single cycle", int'(refresh_stb), 0);
    endtask

    task automatic t_interval();
        int js [3] = '{0, 3, 7};
        foreach (js[i]) begin
            src_sel = 1'b0; cascade = 1'b0; hold = 1'b0;
            ival_sel = 3'(js[i]);
            do_reset();
            steps(1'b1, 1'b0, (2 << js[i]) - 1);
            check($sformatf("R5 flag early ival %0d", js[i]), int'(irq_flag), 0);
            step(1'b1, 1'b0, 1'b0);
            check($sformatf("R5 flag on time ival %0d", js[i]), int'(irq_flag), 1);
        end
    endtask

    task automatic t_smc_src();
        src_sel = 1'b1; cascade = 1'b0; hold = 1'b0; ival_sel = 3'd1;
        do_reset();
        steps(1'b1, 1'b0, 4);
        check("R3 aux ignored with sub-main source", int'(irq_flag), 0);
        steps(1'b0, 1'b1, 3);
        check("R3 sub-main before 4th", int'(irq_flag), 0);
        step(1'b0, 1'b1, 1'b0);
        check("R3 sub-main 4th sets flag", int'(irq_flag), 1);
    endtask

    task automatic t_cascade();
        src_sel = 1'b1; cascade = 1'b1; hold = 1'b0; ival_sel = 3'd0;
        do_reset();
        steps(1'b0, 1'b1, 300);
        check("R4 sub-main ignored when chained", int'(irq_flag), 0);
        steps(1'b1, 1'b0, 511);
        check("R4 no flag before 512 aux", int'(irq_flag), 0);
        step(1'b1, 1'b0, 1'b0);
        check("R4 flag at 512 aux", int'(irq_flag), 1);
    endtask

    task automatic t_hold_plain();
        src_sel = 1'b0; cascade = 1'b0; hold = 1'b1;
        ival_sel = 3'd0; rate_sel = 2'd0;
        do_reset();
        steps(1'b1, 1'b0, 32);
        check("R6 refresh runs during hold", ref_cnt, 1);
        check("R6 stage two frozen", int'(irq_flag), 0);
        hold = 1'b0;
        step(1'b1, 1'b0, 1'b0);
        check("R6 count kept at zero", int'(irq_flag), 0);
        step(1'b1, 1'b0, 1'b0);
        check("R6 resumes after hold", int'(irq_flag), 1);
    endtask

    task automatic t_hold_casc();
        src_sel = 1'b0; cascade = 1'b1; hold = 1'b1; rate_sel = 2'd0;
        do_reset();
        steps(1'b1, 1'b0, 64);
        check("R7 refresh stopped when chained hold", ref_cnt, 0);
        hold = 1'b0;
        steps(1'b1, 1'b0, 32);
        check("R7 stage one resumes from zero", ref_cnt, 1);
    endtask

    task automatic t_flag();
        src_sel = 1'b0; cascade = 1'b0; hold = 1'b0; ival_sel = 3'd0;
        do_reset();
        steps(1'b1, 1'b0, 2);
        check("R8 flag set", int'(irq_flag), 1);
        steps(1'b0, 1'b0, 5);
        check("R8 flag sticky", int'(irq_flag), 1);
        step(1'b0, 1'b0, 1'b1);
        check("R8 flag cleared", int'(irq_flag), 0);
        step(1'b1, 1'b0, 1'b0);
        check("R8 no set off tap", int'(irq_flag), 0);
        step(1'b1, 1'b0, 1'b1);
        check("R9 set wins over clear", int'(irq_flag), 1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_refresh();
        t_interval();
        t_smc_src();
        t_cascade();
        t_hold_plain();
        t_hold_casc();
        t_flag();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule